// File: doc/BRIEF.md
# Parallel Byte-Lane Carry/Borrow-Save Unit

This block performs one arithmetic step on eight independent 8-bit lanes at once. Each lane combines an accumulator byte with a memory byte and one flag bit. The flag bits are held together in a separate flag byte. Depending on the opcode, a flag bit is a carry (weight +1) or a borrow (weight -1). No carry crosses from one lane to the next inside an operation. Each lane's outgoing flag is written into the flag byte one lane higher, so the next operation adds it into the next-higher lane. The result is a redundant wide number: a value byte vector plus a flag byte, which can be fed back as the input of a later step.

Four operations are offered: add with carry, subtract with borrow, add an unsigned vector to a signed (borrow-save) value, and negate a signed value. The unit reports the flag that leaves the top lane. After a signed add it also reports whether one more most-significant byte of value 1 must be appended. Converting back to plain binary, comparing, and sequencing several words belong to the caller.

Operands enter through a valid/ready input stream, and results leave through a valid/ready output stream with a single output register. A transfer happens on a rising clock edge where valid and ready are both high. The unit raises `in_ready` whenever its output register is empty, or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds every field unchanged and no new operand is taken.

Top module: `lane_save_unit`

## Requirements
- R1: Opcode 0 (add with carry): for each lane i (bits 8i+7..8i of the vectors, bit i of `in_flags`), result = (A+M+C) mod 256 and new flag = (A+M+C) div 256.
- R2: Opcode 1 (subtract with borrow): result = (A-M-B+256) mod 256 and new flag = 1-((A-M-B+256) div 256).
- R3: Opcode 2 (signed add): result = (A-B+M+1) mod 256 and new flag = 1-((A-B+M+1) div 256).
- R4: Opcode 3 (negate): result = (255-A+B+1) mod 256, where B is the lane's flag bit used as a byte, and new flag = 1 minus the carry out of that sum. The memory vector has no effect.
- R5: `out_flags` bit i+1 carries the new flag of lane i. `out_flags` bit 0 is 1 for opcode 2 and 0 for the other opcodes. `out_top` is the new flag of lane 7.
- R6: `out_extend` is 1 exactly when the opcode is 2 and `out_top` is 0.
- R7: Lanes are independent: a lane's result never depends on any other lane's data.
- R8: An operand accepted on a clock edge is presented with `out_valid` high after that edge.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, all output fields stay stable.
- R10: A synchronous active-high reset clears `out_valid`, `out_res`, `out_flags`, `out_top` and `out_extend`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand stream valid |
| in_ready | output | 1 | Operand stream ready |
| in_op | input | 2 | Opcode: 0 add-carry, 1 sub-borrow, 2 signed add, 3 negate |
| in_acc | input | 64 | Accumulator lanes |
| in_mem | input | 64 | Memory lanes |
| in_flags | input | 8 | Per-lane carry/borrow bits |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_res | output | 64 | Lane results |
| out_flags | output | 8 | Shifted flag byte with bottom fill |
| out_top | output | 1 | Flag shifted out of the top lane |
| out_extend | output | 1 | Extra high byte of 1 required (signed add) |

## Verification
Each opcode is tried with all-zero lanes, with all-0xFF lanes and every flag set, and with mixed flag patterns. These separate a correct per-lane flag from one that leaks into a neighbour, and also catch a wrong bottom fill. Long runs of random operands with random opcodes test the modulo and divide-by-256 arithmetic against an independent integer model, and they also exercise the extend output for signed adds in both polarities. For negation, two calls with the same accumulator and flags but different memory vectors show that the memory input is ignored. A held output with operands waiting shows the back-pressure rule, and a reset that arrives while a result is pending shows the clearing.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    OP_ADC = 2'd0,
    OP_SBB = 2'd1,
    OP_ADB = 2'd2,
    OP_NEG = 2'd3
  } op_e;
endpackage

// File: rtl/lsu_lane.sv
module lsu_lane
  import lsu_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic         flag_in,
  output logic [W-1:0] res,
  output logic         flag_out
);
  logic [W-1:0] x, y;
  logic         cin;
  logic         carry_is_flag;
  logic [W:0]   sum;

  // Every opcode is reduced to one W-bit addition with carry-in.
  always_comb begin
    x = a;
    y = m;
    cin = flag_in;
    carry_is_flag = 1'b1;
    case (op)
      OP_ADC: begin
        y = m; cin = flag_in; carry_is_flag = 1'b1;
      end
      OP_SBB: begin
        y = ~m; cin = ~flag_in; carry_is_flag = 1'b0;
      end
      OP_ADB: begin
        y = m; cin = ~flag_in; carry_is_flag = 1'b0;
      end
      default: begin
        x = ~a;
        y = {{(W-1){1'b0}}, flag_in};
        cin = 1'b1;
        carry_is_flag = 1'b0;
      end
    endcase
  end

  assign sum      = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign res      = sum[W-1:0];
  assign flag_out = carry_is_flag ? sum[W] : ~sum[W];
endmodule

// File: rtl/lsu_lane_array.sv
module lsu_lane_array
  import lsu_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 8,
  localparam int VW   = LANES * W
) (
  input  op_e              op,
  input  logic [VW-1:0]    acc,
  input  logic [VW-1:0]    mem,
  input  logic [LANES-1:0] flags,
  output logic [VW-1:0]    res,
  output logic [LANES-1:0] lane_flags
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lsu_lane #(.W(W)) u_lane (
      .op      (op),
      .a       (acc[i*W +: W]),
      .m       (mem[i*W +: W]),
      .flag_in (flags[i]),
      .res     (res[i*W +: W]),
      .flag_out(lane_flags[i])
    );
  end
endmodule

// File: rtl/lsu_flag_shift.sv
module lsu_flag_shift
  import lsu_pkg::*;
#(
  parameter int LANES = 8
) (
  input  op_e              op,
  input  logic [LANES-1:0] lane_flags,
  output logic [LANES-1:0] shifted,
  output logic             top,
  output logic             extend
);
  logic fill;
  assign fill    = (op == OP_ADB);
  assign shifted = {lane_flags[LANES-2:0], fill};
  assign top     = lane_flags[LANES-1];
  assign extend  = fill & ~top;
endmodule

// File: rtl/lane_save_unit.sv
module lane_save_unit
  import lsu_pkg::*;
#(
  parameter int LANES = 8,
  parameter int W     = 8,
  localparam int VW   = LANES * W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [VW-1:0]    in_acc,
  input  logic [VW-1:0]    in_mem,
  input  logic [LANES-1:0] in_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VW-1:0]    out_res,
  output logic [LANES-1:0] out_flags,
  output logic             out_top,
  output logic             out_extend
);
  op_e              op;
  logic [VW-1:0]    res_c;
  logic [LANES-1:0] lane_flags_c, shifted_c;
  logic             top_c, ext_c, accept;

  assign op       = op_e'(in_op);
  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  lsu_lane_array #(.LANES(LANES), .W(W)) u_lanes (
    .op        (op),
    .acc       (in_acc),
    .mem       (in_mem),
    .flags     (in_flags),
    .res       (res_c),
    .lane_flags(lane_flags_c)
  );

  lsu_flag_shift #(.LANES(LANES)) u_shift (
    .op        (op),
    .lane_flags(lane_flags_c),
    .shifted   (shifted_c),
    .top       (top_c),
    .extend    (ext_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_res    <= '0;
      out_flags  <= '0;
      out_top    <= 1'b0;
      out_extend <= 1'b0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_res    <= res_c;
      out_flags  <= shifted_c;
      out_top    <= top_c;
      out_extend <= ext_c;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R8: an accepted operand is presented on the next cycle
  a_r8_accept_latency: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R9: a stalled result keeps every field
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_res)
      && $stable(out_flags) && $stable(out_top) && $stable(out_extend));

  // R6: extend only after a signed add (fill 1) whose top flag is clear
  a_r6_extend_fill: assert property (@(posedge clk) disable iff (rst)
    out_extend |-> out_flags[0] && !out_top);

  // R10: reset empties the output register
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> !out_valid && out_flags == '0 && out_res == '0 && !out_extend);
endmodule

// File: tb/sim_lane_save_unit.sv
`timescale 1ns/1ps
module sim_lane_save_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid, out_top, out_extend;
  logic [1:0]  in_op = 2'd0;
  logic [63:0] in_acc = '0, in_mem = '0, out_res;
  logic [7:0]  in_flags = '0, out_flags;
  int errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  lane_save_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc(in_acc), .in_mem(in_mem), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_flags(out_flags), .out_top(out_top), .out_extend(out_extend)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] op, input logic [63:0] a, input logic [63:0] m,
                                input logic [7:0] f, output logic [63:0] r,
                                output logic [7:0] fo, output logic top, output logic ext);
    logic [7:0] nf;
    for (int i = 0; i < 8; i++) begin
      int av, mv, fv, s, n;
      av = int'(a[i*8 +: 8]); mv = int'(m[i*8 +: 8]); fv = int'(f[i]);
      case (op)
        2'd0: begin s = av + mv + fv;        n = s / 256;     end
        2'd1: begin s = av - mv - fv + 256;  n = 1 - s / 256; end
        2'd2: begin s = av - fv + mv + 1;    n = 1 - s / 256; end
        default: begin s = 255 - av + fv + 1; n = 1 - s / 256; end
      endcase
      r[i*8 +: 8] = 8'(s % 256);
      nf[i] = n[0];
    end
    fo  = {nf[6:0], op == 2'd2};
    top = nf[7];
    ext = (op == 2'd2) && !nf[7];
  endfunction

  function automatic string tag(input logic [1:0] op);
    case (op)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // drive at negedge, result visible at the following negedge
  task automatic run(input logic [1:0] op, input logic [63:0] a, input logic [63:0] m,
                     input logic [7:0] f);
    logic [63:0] er; logic [7:0] ef; logic et, ee;
    model(op, a, m, f, er, ef, et, ee);
    @(negedge clk);
    in_op = op; in_acc = a; in_mem = m; in_flags = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 valid", 64'(out_valid), 64'd1);
    chk({tag(op), " R7 result"}, out_res, er);
    chk("R5 flags", 64'(out_flags), 64'(ef));
    chk("R5 top", 64'(out_top), 64'(et));
    chk("R6 extend", 64'(out_extend), 64'(ee));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10 reset valid", 64'(out_valid), 64'd0);
    chk("R10 reset res", out_res, 64'd0);
    chk("R10 reset flags", 64'(out_flags), 64'd0);
    chk("R9 ready empty", 64'(in_ready), 64'd1);
    rst = 1'b0;

    // directed corners for each opcode
    for (int op = 0; op < 4; op++) begin
      run(2'(op), 64'd0, 64'd0, 8'h00);
      run(2'(op), '1, '1, 8'hFF);
      run(2'(op), '1, 64'd0, 8'h55);
      run(2'(op), 64'h00FF_00FF_00FF_00FF, 64'h0100_0100_0100_0100, 8'hAA);
    end
    // R7: lane 0 overflows, neighbours must stay put
    run(2'd0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_0001, 8'h00);
    // R4: memory ignored by negate
    run(2'd3, 64'h1234_5678_9ABC_DEF0, 64'd0, 8'h3C);
    run(2'd3, 64'h1234_5678_9ABC_DEF0, '1, 8'h3C);

    // random traffic
    for (int k = 0; k < 400; k++)
      run(2'($urandom_range(0, 3)), {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom));

    // R9: back-pressure
    begin
      logic [63:0] r1, r2; logic [7:0] f1, f2; logic t1, e1, t2, e2;
      model(2'd2, 64'h0102_0304_0506_0708, 64'hF0F0_F0F0_F0F0_F0F0, 8'h0F, r1, f1, t1, e1);
      model(2'd0, 64'hFFFF_0000_FFFF_0000, 64'h0001_0001_0001_0001, 8'hF0, r2, f2, t2, e2);
      @(negedge clk);
      out_ready = 1'b0;
      in_op = 2'd2; in_acc = 64'h0102_0304_0506_0708; in_mem = 64'hF0F0_F0F0_F0F0_F0F0;
      in_flags = 8'h0F; in_valid = 1'b1;
      @(negedge clk);
      in_op = 2'd0; in_acc = 64'hFFFF_0000_FFFF_0000; in_mem = 64'h0001_0001_0001_0001;
      in_flags = 8'hF0;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk("R9 held valid", 64'(out_valid), 64'd1);
        chk("R9 not ready", 64'(in_ready), 64'd0);
        chk("R9 held res", out_res, r1);
        chk("R9 held flags", 64'(out_flags), 64'(f1));
        chk("R9 held extend", 64'(out_extend), 64'(e1));
      end
      out_ready = 1'b1;
      #0.5;
      chk("R9 ready on drain", 64'(in_ready), 64'd1);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 next res", out_res, r2);
      chk("R9 next flags", 64'(out_flags), 64'(f2));
      chk("R9 next top", 64'(out_top), 64'(t2));
    end

    // R10: reset while a result waits
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 2'd2; in_acc = 64'd5; in_mem = 64'd9; in_flags = 8'h00; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; out_ready = 1'b1;
    chk("R10 mid valid", 64'(out_valid), 64'd0);
    chk("R10 mid res", out_res, 64'd0);
    chk("R10 mid flags", 64'(out_flags), 64'd0);
    chk("R10 mid extend", 64'(out_extend), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule